// File: doc/BRIEF.md
# Pixel Link Word Formatter

This block sits between a 24-bit parallel video source and a narrow serial pixel link. Each pixel carries 8-bit red, green and blue values plus vertical sync, horizontal sync and data enable. The block can first pass each colour through its own 256-entry correction table. It then keeps the upper six bits of every channel and builds a 24-bit link word. That word holds the 18 colour bits, the three sync and enable bits unchanged, a rolling 2-bit sequence count and an odd parity bit. A receiver uses the sequence count and parity to find word alignment again without any coding expansion.

The design runs on one clock whose period is one serial bit slot, meaning one edge of the serial clock. A word leaves the block over 8 slots on three lanes or over 12 slots on two lanes. The block asks for the next pixel with a one-cycle sample strobe, so the pixel rate follows from the lane count. A slot index and a word-start strobe tell the analog serialiser where each bit sits in the word.

Top module: `pixel_frame_fmt`

## Requirements
- R1: After reset, with streaming off, `lane_valid`, `word_start` and `pix_take` are 0, `slot_idx` is 0 and `lane_bits` is 0.
- R2: Each colour field in the word is bits 7..2 of the selected channel value; bits 1..0 are dropped.
- R3: The link word layout is red[23:18], green[17:12], blue[11:6], vertical sync[5], horizontal sync[4], data enable[3], sequence[2:1], parity[0]. The three control bits are copied unchanged from the inputs sampled with the pixel.
- R4: The first word after streaming is enabled carries sequence 0. Each later word carries the previous value plus one, modulo 4.
- R5: Parity is odd over the whole 24-bit word, so the word holds an odd number of ones.
- R6: In slot k, lane j carries word bit 23-(k*L+j), where L is 3 in three-lane mode and 2 in two-lane mode. This sends the word most significant bit first, round robin across the lanes. Lane 2 is held at 0 in two-lane mode.
- R7: While streaming, `pix_take` is high for one cycle in every 8 (three-lane) or 12 (two-lane). The word sampled at that edge appears from the next cycle with `word_start` high and `slot_idx` counting 0 up to the last slot.
- R8: When the lookup is active for a pixel, each 8-bit channel value is replaced by its own table's entry at that address before truncation. Table writes use select 0 for red, 1 for green and 2 for blue. Select 3 writes nothing.
- R9: `lane3_sel` (1 = three lanes) and `lut_en` take effect only at the edge where `pix_take` is high. Changes at any other time leave the word in flight unaltered.
- R10: When `stream_en` is low, the next cycle shows `lane_valid` low and `lane_bits` zero, and the sequence count restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-slot clock |
| rst | input | 1 | Synchronous active-high reset |
| stream_en | input | 1 | Enables word formation and output |
| lane3_sel | input | 1 | 1 selects three lanes, 0 two lanes |
| lut_en | input | 1 | Applies the correction tables |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_sel | input | 2 | Table select (0 red, 1 green, 2 blue) |
| tbl_wr_addr | input | 8 | Table entry address |
| tbl_wr_data | input | 8 | Table entry value |
| red_in | input | 8 | Red channel |
| grn_in | input | 8 | Green channel |
| blu_in | input | 8 | Blue channel |
| vsync_in | input | 1 | Vertical sync |
| hsync_in | input | 1 | Horizontal sync |
| den_in | input | 1 | Data enable |
| pix_take | output | 1 | Pixel inputs are sampled at the coming edge |
| lane_valid | output | 1 | Lane bits carry word data |
| word_start | output | 1 | First slot of a word |
| slot_idx | output | 4 | Current slot within the word |
| lane_bits | output | 3 | One bit per lane for this slot |

## Verification
The bench rebuilds every word from the lane bits. A mapping that reversed lane order or bit order would give scrambled words that fail the comparison. It flips the lane count and the lookup enable in the middle of words. A design that read the live mode pins instead of the latched ones would cut a word short or decode it with the wrong table. Turning streaming off partway through a word must restart the sequence at 0, or the first word after re-enable carries a stale count. All-ones and all-zeros pixels, and values with only the two dropped bits set, test the parity polarity and the truncation.

// File: rtl/pff_pkg.sv
package pff_pkg;

    localparam int CH_IN_W      = 8;
    localparam int CH_OUT_W     = 6;
    localparam int N_CH         = 3;
    localparam int SEQ_W        = 2;
    localparam int CTL_W        = 3;
    localparam int WORD_W       = N_CH * CH_OUT_W + CTL_W + SEQ_W + 1;
    localparam int LANES_MAX    = 3;
    localparam int LANES_MIN    = 2;
    localparam int SLOTS_WIDE   = WORD_W / LANES_MAX;
    localparam int SLOTS_NARROW = WORD_W / LANES_MIN;
    localparam int SLOT_W       = $clog2(SLOTS_NARROW);
    localparam int TBL_DEPTH    = 1 << CH_IN_W;
    localparam int SEL_W        = $clog2(N_CH + 1);
    localparam int DROP_W       = CH_IN_W - CH_OUT_W;

    typedef enum logic {
        LANES_TWO   = 1'b0,
        LANES_THREE = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic [CH_IN_W-1:0] red;
        logic [CH_IN_W-1:0] grn;
        logic [CH_IN_W-1:0] blu;
    } pix_in_t;

    typedef struct packed {
        logic vsync;
        logic hsync;
        logic den;
    } sync_t;

    typedef struct packed {
        logic [CH_OUT_W-1:0] red;
        logic [CH_OUT_W-1:0] grn;
        logic [CH_OUT_W-1:0] blu;
        sync_t               sync;
        logic [SEQ_W-1:0]    seq;
        logic                par;
    } link_word_t;

    function automatic int lanes_of(lane_mode_e m);
        return (m == LANES_THREE) ? LANES_MAX : LANES_MIN;
    endfunction

    function automatic logic [SLOT_W-1:0] last_slot(lane_mode_e m);
        return (m == LANES_THREE) ? SLOT_W'(SLOTS_WIDE - 1) : SLOT_W'(SLOTS_NARROW - 1);
    endfunction

    // Fill bit making the total count of ones odd.
    function automatic logic odd_fill(logic [WORD_W-2:0] body);
        return ~(^body);
    endfunction

endpackage

// File: rtl/pff_lut_bank.sv
module pff_lut_bank
    import pff_pkg::*;
#(
    parameter int DATA_W   = CH_IN_W,
    parameter int CHANNELS = N_CH,
    parameter int SELW     = SEL_W,
    localparam int DEPTH   = 1 << DATA_W,
    localparam int BUS_W   = CHANNELS * DATA_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SELW-1:0]   wr_sel,
    input  logic [DATA_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BUS_W-1:0]  rd_addr,
    output logic [BUS_W-1:0]  rd_data
);

    // Channel 0 occupies the most significant slice of the bus.
    for (genvar c = 0; c < CHANNELS; c++) begin : g_tbl
        localparam int LSB = (CHANNELS - 1 - c) * DATA_W;
        logic [DATA_W-1:0] tbl [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == SELW'(c))) begin
                tbl[wr_addr] <= wr_data;
            end
        end

        assign rd_data[LSB +: DATA_W] = tbl[rd_addr[LSB +: DATA_W]];
    end

endmodule

// File: rtl/pff_word_builder.sv
module pff_word_builder
    import pff_pkg::*;
(
    input  pix_in_t          raw,
    input  pix_in_t          mapped,
    input  logic             use_map,
    input  sync_t            sync,
    input  logic [SEQ_W-1:0] seq,
    output link_word_t       word
);

    pix_in_t             src;
    link_word_t          body;
    logic [3*DROP_W-1:0] trunc_unused;

    always_comb begin
        src       = use_map ? mapped : raw;
        body      = '0;
        body.red  = src.red[CH_IN_W-1 -: CH_OUT_W];
        body.grn  = src.grn[CH_IN_W-1 -: CH_OUT_W];
        body.blu  = src.blu[CH_IN_W-1 -: CH_OUT_W];
        body.sync = sync;
        body.seq  = seq;
        word      = body;
        word.par  = odd_fill(body[WORD_W-1:1]);
    end

    assign trunc_unused = {src.red[DROP_W-1:0], src.grn[DROP_W-1:0], src.blu[DROP_W-1:0]};

endmodule

// File: rtl/pff_cadence.sv
module pff_cadence
    import pff_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stream_en,
    input  lane_mode_e        mode_in,
    output logic              take,
    output logic              run,
    output logic [SLOT_W-1:0] slot,
    output lane_mode_e        mode_q,
    output logic [SEQ_W-1:0]  seq_q
);

    logic at_last;

    assign at_last = (slot == last_slot(mode_q));
    assign take    = stream_en && (!run || at_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            slot   <= '0;
            seq_q  <= '0;
            mode_q <= LANES_TWO;
        end else if (!stream_en) begin
            run   <= 1'b0;
            slot  <= '0;
            seq_q <= '0;
        end else if (take) begin
            run    <= 1'b1;
            slot   <= '0;
            seq_q  <= seq_q + SEQ_W'(1);
            mode_q <= mode_in;
        end else begin
            slot <= slot + SLOT_W'(1);
        end
    end

endmodule

// File: rtl/pff_slot_mapper.sv
module pff_slot_mapper
    import pff_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    parameter int LANES = LANES_MAX,
    parameter int SW    = SLOT_W
) (
    input  logic [WIDTH-1:0] word,
    input  logic [SW-1:0]    slot,
    input  lane_mode_e       mode,
    input  logic             active,
    output logic [LANES-1:0] bits
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic lane_bit;
        int   pos;

        always_comb begin
            pos      = int'(slot) * lanes_of(mode) + j;
            lane_bit = 1'b0;
            if (active && (j < lanes_of(mode)) && (pos < WIDTH)) begin
                lane_bit = word[WIDTH-1-pos];
            end
        end

        assign bits[j] = lane_bit;
    end

endmodule

// File: rtl/pixel_frame_fmt.sv
module pixel_frame_fmt
    import pff_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stream_en,
    input  logic                 lane3_sel,
    input  logic                 lut_en,
    input  logic                 tbl_wr_en,
    input  logic [SEL_W-1:0]     tbl_wr_sel,
    input  logic [CH_IN_W-1:0]   tbl_wr_addr,
    input  logic [CH_IN_W-1:0]   tbl_wr_data,
    input  logic [CH_IN_W-1:0]   red_in,
    input  logic [CH_IN_W-1:0]   grn_in,
    input  logic [CH_IN_W-1:0]   blu_in,
    input  logic                 vsync_in,
    input  logic                 hsync_in,
    input  logic                 den_in,
    output logic                 pix_take,
    output logic                 lane_valid,
    output logic                 word_start,
    output logic [SLOT_W-1:0]    slot_idx,
    output logic [LANES_MAX-1:0] lane_bits
);

    pix_in_t           raw_pix;
    pix_in_t           tbl_pix;
    sync_t             sync_in;
    link_word_t        next_word;
    link_word_t        word_q;
    logic              cad_take;
    logic              cad_run;
    logic [SLOT_W-1:0] cad_slot;
    lane_mode_e        cad_lane3;
    logic [SEQ_W-1:0]  cad_fseq;

    assign raw_pix = '{red: red_in, grn: grn_in, blu: blu_in};
    assign sync_in = '{vsync: vsync_in, hsync: hsync_in, den: den_in};

    pff_cadence u_cadence (
        .clk       (clk),
        .rst       (rst),
        .stream_en (stream_en),
        .mode_in   (lane_mode_e'(lane3_sel)),
        .take      (cad_take),
        .run       (cad_run),
        .slot      (cad_slot),
        .mode_q    (cad_lane3),
        .seq_q     (cad_fseq)
    );

    pff_lut_bank u_tables (
        .clk     (clk),
        .wr_en   (tbl_wr_en),
        .wr_sel  (tbl_wr_sel),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_addr (raw_pix),
        .rd_data (tbl_pix)
    );

    pff_word_builder u_builder (
        .raw     (raw_pix),
        .mapped  (tbl_pix),
        .use_map (lut_en),
        .sync    (sync_in),
        .seq     (cad_fseq),
        .word    (next_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (cad_take) begin
            word_q <= next_word;
        end
    end

    pff_slot_mapper u_mapper (
        .word   (word_q),
        .slot   (cad_slot),
        .mode   (cad_lane3),
        .active (cad_run),
        .bits   (lane_bits)
    );

    assign pix_take   = cad_take;
    assign lane_valid = cad_run;
    assign word_start = cad_run && (cad_slot == '0);
    assign slot_idx   = cad_slot;

endmodule

// File: rtl/pixel_frame_fmt_chk.sv
module pixel_frame_fmt_chk
    import pff_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              stream_en,
    input logic              pix_take,
    input logic              lane_valid,
    input logic              word_start,
    input logic [SLOT_W-1:0] slot_idx,
    input logic              lane_top,
    input logic              lane3_q,
    input logic [SEQ_W-1:0]  fseq_q,
    input logic [WORD_W-1:0] word_q,
    input logic              vsync_in,
    input logic              hsync_in,
    input logic              den_in
);

    AST_STREAM_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !stream_en |=> !lane_valid); // R10

    AST_SEQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
        !stream_en |=> (fseq_q == '0)); // R10

    AST_PARITY_ODD: assert property (@(posedge clk) disable iff (rst)
        lane_valid |-> (^word_q == 1'b1)); // R5

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (pix_take && lane_valid) |=> (fseq_q == SEQ_W'($past(fseq_q) + 1))); // R4

    AST_FIRST_SEQ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pix_take && !lane_valid) |=> (word_q[2:1] == 2'b00)); // R4

    AST_TAKE_THEN_START: assert property (@(posedge clk) disable iff (rst)
        pix_take |=> word_start); // R7

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
        lane_valid |-> (slot_idx <= (lane3_q ? SLOT_W'(SLOTS_WIDE - 1) : SLOT_W'(SLOTS_NARROW - 1)))); // R7

    AST_SPARE_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (lane_valid && !lane3_q) |-> !lane_top); // R6

    AST_CTRL_COPY: assert property (@(posedge clk) disable iff (rst)
        pix_take |=> (word_q[5:3] == $past({vsync_in, hsync_in, den_in}))); // R3

endmodule

bind pixel_frame_fmt pixel_frame_fmt_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .stream_en  (stream_en),
    .pix_take   (pix_take),
    .lane_valid (lane_valid),
    .word_start (word_start),
    .slot_idx   (slot_idx),
    .lane_top   (lane_bits[2]),
    .lane3_q    (cad_lane3),
    .fseq_q     (cad_fseq),
    .word_q     (word_q),
    .vsync_in   (vsync_in),
    .hsync_in   (hsync_in),
    .den_in     (den_in)
);

// File: tb/pixel_frame_fmt_tb_top.sv
module pixel_frame_fmt_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stream_en = 1'b0;
    logic       lane3_sel = 1'b0;
    logic       lut_en = 1'b0;
    logic       tbl_wr_en = 1'b0;
    logic [1:0] tbl_wr_sel = '0;
    logic [7:0] tbl_wr_addr = '0;
    logic [7:0] tbl_wr_data = '0;
    logic [7:0] red_in = '0, grn_in = '0, blu_in = '0;
    logic       vsync_in = 1'b0, hsync_in = 1'b0, den_in = 1'b0;
    logic       pix_take, lane_valid, word_start;
    logic [3:0] slot_idx;
    logic [2:0] lane_bits;

    int          checks = 0;
    int          fails = 0;
    int          fseq_m = 0;
    logic [23:0] exp_q[$];
    bit          exp_m[$];
    logic [23:0] acc = '0;
    int          acc_cnt = 0;
    bit          cad_ok = 1'b1;
    bit          lane_ok = 1'b1;
    bit          have_f = 1'b0;
    logic [1:0]  last_f = '0;
    bit          toggle_modes = 1'b0;

    always #2 clk = ~clk;

    pixel_frame_fmt dut_i (
        .clk(clk), .rst(rst), .stream_en(stream_en), .lane3_sel(lane3_sel), .lut_en(lut_en),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_sel(tbl_wr_sel), .tbl_wr_addr(tbl_wr_addr),
        .tbl_wr_data(tbl_wr_data), .red_in(red_in), .grn_in(grn_in), .blu_in(blu_in),
        .vsync_in(vsync_in), .hsync_in(hsync_in), .den_in(den_in), .pix_take(pix_take),
        .lane_valid(lane_valid), .word_start(word_start), .slot_idx(slot_idx), .lane_bits(lane_bits)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] lut_fn(input int ch, input logic [7:0] a);
        case (ch)
            0:       return a ^ 8'h5A;
            1:       return ~a;
            default: return a + 8'd37;
        endcase
    endfunction

    function automatic logic [23:0] exp_word(input logic [7:0] r, g, b, input logic v, h, d,
                                             input logic [1:0] f, input bit use_tbl);
        logic [7:0]  rr, gg, bb;
        logic [23:0] w;
        rr = use_tbl ? lut_fn(0, r) : r;
        gg = use_tbl ? lut_fn(1, g) : g;
        bb = use_tbl ? lut_fn(2, b) : b;
        w = {rr[7:2], gg[7:2], bb[7:2], v, h, d, f, 1'b0};
        if ((^w) == 1'b0) w[0] = 1'b1;
        return w;
    endfunction

    task automatic monitor();
        if (lane_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "output without sampled pixel", 32'(slot_idx), 32'hFFFF);
            end else begin
                int nl = exp_m[0] ? 3 : 2;
                int ns = 24 / nl;
                if (slot_idx != 4'(acc_cnt)) cad_ok = 1'b0;
                if (word_start != (acc_cnt == 0)) cad_ok = 1'b0;
                if (!exp_m[0] && lane_bits[2]) lane_ok = 1'b0;
                for (int j = 0; j < nl; j++) acc[23 - (acc_cnt * nl + j)] = lane_bits[j];
                acc_cnt++;
                if (acc_cnt == ns) begin
                    chk(acc == exp_q[0], "R2 R3 R6 R8 R9", "reassembled word", 32'(acc), 32'(exp_q[0]));
                    chk((^acc) == 1'b1, "R5", "odd parity", 32'(^acc), 32'd1);
                    chk(cad_ok, "R7", "slot sequence and start strobe", 32'(cad_ok), 32'd1);
                    chk(lane_ok, "R6", "spare lane quiet in two-lane mode", 32'(lane_ok), 32'd1);
                    if (have_f)
                        chk(acc[2:1] == last_f + 2'd1, "R4", "sequence step", 32'(acc[2:1]), 32'(last_f + 2'd1));
                    else
                        chk(acc[2:1] == 2'd0, "R4", "first sequence after enable", 32'(acc[2:1]), 32'd0);
                    last_f = acc[2:1];
                    have_f = 1'b1;
                    void'(exp_q.pop_front());
                    void'(exp_m.pop_front());
                    acc_cnt = 0;
                    cad_ok = 1'b1;
                    lane_ok = 1'b1;
                end
            end
        end
    endtask

    task automatic tick();
        @(negedge clk);
        monitor();
    endtask

    task automatic send_pixel(input logic [7:0] r, g, b, input logic v, h, d);
        while (!pix_take) begin
            tick();
            if (toggle_modes && !pix_take) begin
                lane3_sel = 1'($urandom);
                lut_en = 1'($urandom);
            end
        end
        red_in = r; grn_in = g; blu_in = b;
        vsync_in = v; hsync_in = h; den_in = d;
        exp_q.push_back(exp_word(r, g, b, v, h, d, 2'(fseq_m), lut_en));
        exp_m.push_back(lane3_sel);
        fseq_m = (fseq_m + 1) % 4;
        tick();
    endtask

    task automatic send_random(input int n);
        for (int i = 0; i < n; i++)
            send_pixel(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    endtask

    task automatic start_stream();
        stream_en = 1'b1;
        #1;
    endtask

    task automatic stop_stream();
        stream_en = 1'b0;
        exp_q.delete();
        exp_m.delete();
        acc_cnt = 0;
        cad_ok = 1'b1;
        lane_ok = 1'b1;
        have_f = 1'b0;
        fseq_m = 0;
        tick();
        chk(!lane_valid, "R10", "lane_valid after stream off", 32'(lane_valid), 32'd0);
        chk(lane_bits == 3'd0, "R10", "lane_bits after stream off", 32'(lane_bits), 32'd0);
    endtask

    task automatic drain_and_stop();
        while (exp_q.size() > 0) tick();
        stop_stream();
    endtask

    task automatic tbl_write(input logic [1:0] sel, input logic [7:0] addr, input logic [7:0] data);
        tbl_wr_en = 1'b1; tbl_wr_sel = sel; tbl_wr_addr = addr; tbl_wr_data = data;
        tick();
        tbl_wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (4) tick();
        rst = 1'b0;
        tick();
        tick();
        // R1 reset state
        chk(!lane_valid, "R1", "lane_valid after reset", 32'(lane_valid), 32'd0);
        chk(!word_start, "R1", "word_start after reset", 32'(word_start), 32'd0);
        chk(!pix_take, "R1", "pix_take after reset", 32'(pix_take), 32'd0);
        chk(slot_idx == 4'd0, "R1", "slot_idx after reset", 32'(slot_idx), 32'd0);
        chk(lane_bits == 3'd0, "R1", "lane_bits after reset", 32'(lane_bits), 32'd0);

        // R8 table load, then select 3 writes that must leave tables untouched
        for (int ch = 0; ch < 3; ch++)
            for (int a = 0; a < 256; a++)
                tbl_write(2'(ch), 8'(a), lut_fn(ch, 8'(a)));
        tbl_write(2'd3, 8'h10, 8'hC3);
        tbl_write(2'd3, 8'hF0, 8'h00);

        // Three lanes, no lookup, directed corners first (R2 truncation, R5 parity polarity)
        lane3_sel = 1'b1; lut_en = 1'b0;
        start_stream();
        send_pixel(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1);
        send_pixel(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        send_pixel(8'h03, 8'h03, 8'h03, 1'b1, 1'b0, 1'b1);
        send_random(16);
        drain_and_stop();

        // Two lanes with lookup, including addresses hit by the ignored select-3 writes (R8)
        lane3_sel = 1'b0; lut_en = 1'b1;
        start_stream();
        send_pixel(8'h10, 8'h10, 8'h10, 1'b0, 1'b1, 1'b0);
        send_pixel(8'hF0, 8'hF0, 8'hF0, 1'b1, 1'b1, 1'b0);
        send_random(16);
        drain_and_stop();

        // Stream dropped mid-word: sequence must restart at 0 (R10, R4)
        lane3_sel = 1'b1; lut_en = 1'b0;
        start_stream();
        send_random(2);
        repeat (3) tick();
        stop_stream();
        start_stream();
        send_random(5);
        drain_and_stop();

        // Mode pins toggled between sample edges (R9)
        toggle_modes = 1'b1;
        start_stream();
        send_random(60);
        toggle_modes = 1'b0;
        drain_and_stop();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule